// File: doc/BRIEF.md
# SPI Master Slave-Select Sequencer

This block is the front end of a register-programmed SPI master with four slave-select outputs. Software programs a control register (enable, start, target channel, bits per word) and a configuration register (per-channel select polarity and per-channel hold-across-words control). It fills a 32-bit transmit queue and then writes the start bit. The block drains the queue word by word, shifting each word out on MOSI in SPI mode 0, and collects the MISO bits into a word that goes to a receive queue.

Only the chosen select line moves during a transfer. It goes to that channel's active level when draining begins. It goes back to its idle level in the same clock edge that raises the done flag, once the last bit of the last word has been sampled and the transmit queue is empty. Every other select line stays at the idle level given by its own polarity bit, and a polarity change shows on an idle line right after the write.

Top module: `spi_ssel_master`

## Requirements
- R1: After reset all four select lines read 1, SCLK is 0, the receive queue is empty, control and configuration read 0 and status reads 0x3.
- R2: Configuration bit 12+i is the polarity of channel i (1 = active high, 0 = active low). An idle line i drives the inverse of that bit from the clock edge that takes the write.
- R3: During a transfer, the line picked by control bits 3:2 is at its active level whenever SCLK is high. All other lines stay at their idle level for the whole transfer.
- R4: Control bits 13:8 hold the bits per word minus one, and values 31 to 63 all give 32 bits. Each word makes exactly that many SCLK pulses. The received word carries each sampled bit at the position of the bit sent in that slot, with zeros above.
- R5: Bytes go out starting from the least significant byte, each byte (or the short final byte) most significant bit first. MOSI changes only while SCLK is low.
- R6: A transfer starts only when a control write sets bit 0 (enable) and bit 1 (start) while the transmit queue holds a word. A start into an empty queue causes no SCLK pulse and no select change. The start bit reads back as 0.
- R7: Status bit 3 (done) is set on the edge that releases the select line, after the final bit with the transmit queue empty. Writing 1 to it clears it, but a hardware set in the same cycle wins.
- R8: Each finished word is pushed to the receive queue. If the queue is full, the word is dropped and status bit 2 (overflow) is set, and writing 1 to that bit clears it.
- R9: Configuration bit 8+i set holds channel i selected across consecutive words. Cleared, the line returns to idle for one gap cycle between words.
- R10: Status bit 0 shows an empty transmit queue and status bit 1 shows a receive queue that is not full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control, 1 configuration, 2 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| tx_push | input | 1 | Push tx_data into the transmit queue |
| tx_data | input | 32 | Word to transmit |
| tx_full | output | 1 | Transmit queue full |
| rx_pop | input | 1 | Pop the head of the receive queue |
| rx_data | output | 32 | Head of the receive queue |
| rx_empty | output | 1 | Receive queue empty |
| sclk | output | 1 | Serial clock, idle low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| ssel | output | 4 | Slave-select lines, one per channel |

## Verification
Two things can land on the same clock edge: the sequencer raising the done flag, and a software write that clears that flag. The bench provokes this by issuing done-clear writes on every cycle from the start of a one-word transfer until it sees the select line go idle. The last of those writes then shares its edge with the hardware set. The flag must still read 1 afterwards, and a later lone clear must bring it to 0.

// File: rtl/spi_ssel_pkg.sv
package spi_ssel_pkg;
   localparam int unsigned REG_AW = 2;

   typedef enum logic [REG_AW-1:0] {
      RA_CTRL = 2'd0,
      RA_CFG  = 2'd1,
      RA_STAT = 2'd2
   } reg_addr_e;

   // control register fields
   localparam int unsigned CT_EN     = 0;
   localparam int unsigned CT_GO     = 1;
   localparam int unsigned CT_CH_LO  = 2;
   localparam int unsigned CT_LEN_LO = 8;
   // configuration register fields
   localparam int unsigned CF_HOLD_LO = 8;
   localparam int unsigned CF_POL_LO  = 12;
   // status register bits
   localparam int unsigned ST_TXE  = 0;
   localparam int unsigned ST_RXNF = 1;
   localparam int unsigned ST_OVF  = 2;
   localparam int unsigned ST_DONE = 3;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_LOAD,
      SQ_RUN,
      SQ_GAP
   } seq_state_e;
endpackage

// File: rtl/spi_ssel_fifo.sv
module spi_ssel_fifo #(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] wdata,
   input  logic             pop,
   output logic [WIDTH-1:0] rdata,
   output logic             full,
   output logic             empty
);
   localparam int unsigned AW = $clog2(DEPTH);
   localparam int unsigned CW = AW + 1;

   generate
      if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
         $error("spi_ssel_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [AW-1:0]    wp_q, rp_q;
   logic [CW-1:0]    cnt_q;
   logic             do_push, do_pop;

   assign full    = (cnt_q == CW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign rdata   = mem_q[rp_q];

   always_ff @(posedge clk) begin
      if (do_push) mem_q[wp_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= wp_q + AW'(1);
         if (do_pop)  rp_q <= rp_q + AW'(1);
         cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
      end
   end
endmodule

// File: rtl/spi_ssel_shift.sv
module spi_ssel_shift #(
   parameter int unsigned WORD_W   = 32,
   parameter int unsigned HALF_DIV = 2,
   localparam int unsigned LW      = $clog2(WORD_W) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [WORD_W-1:0] load_word,
   input  logic [LW-1:0]     bit_len,
   input  logic              miso,
   output logic              sclk,
   output logic              mosi,
   output logic              done,
   output logic [WORD_W-1:0] rx_word
);
   localparam int unsigned DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   generate
      if (WORD_W < 8 || (WORD_W & (WORD_W - 1)) != 0) begin : g_bad_word
         $error("spi_ssel_shift: WORD_W must be a power of two, at least 8");
      end
      if (HALF_DIV < 1) begin : g_bad_div
         $error("spi_ssel_shift: HALF_DIV must be at least 1");
      end
   endgenerate

   logic              busy_q, phase_q, done_q;
   logic [DW-1:0]     div_q;
   logic [LW-1:0]     k_q, len_q;
   logic [WORD_W-1:0] word_q, acc_q;
   logic [LW-1:0]     base, remain, nbits, pos;
   logic              tick;
   logic              unused_pos;

   // slot k -> bit position: bytes ascending, msb first inside each byte
   always_comb begin
      base   = {k_q[LW-1:3], 3'b000};
      remain = len_q - base;
      nbits  = (remain > LW'(8)) ? LW'(8) : remain;
      pos    = base + nbits - LW'(1) - {{(LW-3){1'b0}}, k_q[2:0]};
   end
   assign unused_pos = pos[LW-1];
   assign tick = (div_q == DW'(HALF_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         phase_q <= 1'b0;
         done_q  <= 1'b0;
         div_q   <= '0;
         k_q     <= '0;
         len_q   <= '0;
         word_q  <= '0;
         acc_q   <= '0;
      end else begin
         done_q <= 1'b0;
         if (load) begin
            busy_q  <= 1'b1;
            phase_q <= 1'b0;
            div_q   <= '0;
            k_q     <= '0;
            len_q   <= bit_len;
            word_q  <= load_word;
            acc_q   <= '0;
         end else if (busy_q) begin
            if (!tick) begin
               div_q <= div_q + DW'(1);
            end else begin
               div_q <= '0;
               if (!phase_q) begin
                  phase_q <= 1'b1;
               end else begin
                  phase_q <= 1'b0;
                  acc_q[pos[LW-2:0]] <= miso;
                  if (k_q == len_q - LW'(1)) begin
                     busy_q <= 1'b0;
                     done_q <= 1'b1;
                  end else begin
                     k_q <= k_q + LW'(1);
                  end
               end
            end
         end
      end
   end

   assign sclk    = busy_q & phase_q;
   assign mosi    = busy_q & word_q[pos[LW-2:0]];
   assign done    = done_q;
   assign rx_word = acc_q;
endmodule

// File: rtl/spi_ssel_drive.sv
module spi_ssel_drive #(
   parameter int unsigned NSEL = 4,
   localparam int unsigned CHW = $clog2(NSEL)
) (
   input  logic            act,
   input  logic [CHW-1:0]  chan,
   input  logic [NSEL-1:0] pol,
   output logic [NSEL-1:0] ssel
);
   generate
      for (genvar i = 0; i < NSEL; i++) begin : g_line
         assign ssel[i] = (act && chan == CHW'(i)) ? pol[i] : ~pol[i];
      end
   endgenerate
endmodule

// File: rtl/spi_ssel_master.sv
module spi_ssel_master
   import spi_ssel_pkg::*;
#(
   parameter int unsigned TX_DEPTH = 8,
   parameter int unsigned RX_DEPTH = 4,
   parameter int unsigned HALF_DIV = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_we,
   input  logic [1:0]  reg_addr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   input  logic        tx_push,
   input  logic [31:0] tx_data,
   output logic        tx_full,
   input  logic        rx_pop,
   output logic [31:0] rx_data,
   output logic        rx_empty,
   output logic        sclk,
   output logic        mosi,
   input  logic        miso,
   output logic [3:0]  ssel
);
   localparam int unsigned WORD_W = 32;
   localparam int unsigned NSEL   = 4;
   localparam int unsigned CHW    = $clog2(NSEL);
   localparam int unsigned LW     = $clog2(WORD_W) + 1;

   seq_state_e        state_q;
   logic              act_q, ctrl_en;
   logic [CHW-1:0]    ctrl_ch, chan_q;
   logic [LW-1:0]     ctrl_len, len_eff;
   logic [NSEL-1:0]   cfg_hold, cfg_pol;
   logic              st_ovf, st_done;
   logic              wr_ctrl, wr_cfg, wr_stat, go;
   logic              txq_empty, rxq_full, eng_done, seq_load;
   logic              done_set, ovf_set;
   logic [WORD_W-1:0] txq_head, eng_rx;
   logic              unused_wdata;

   assign unused_wdata = ^{reg_wdata[31:16], reg_wdata[7:4]};

   assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
   assign wr_cfg  = reg_we && (reg_addr == RA_CFG);
   assign wr_stat = reg_we && (reg_addr == RA_STAT);
   assign go      = wr_ctrl && reg_wdata[CT_GO] && reg_wdata[CT_EN] &&
                    !txq_empty && (state_q == SQ_IDLE);
   assign len_eff = (ctrl_len >= LW'(WORD_W - 1)) ? LW'(WORD_W) : ctrl_len + LW'(1);
   assign seq_load = (state_q == SQ_LOAD);
   assign done_set = (state_q == SQ_RUN) && eng_done && txq_empty;
   assign ovf_set  = eng_done && rxq_full && !rx_pop;

   spi_ssel_fifo #(.WIDTH(WORD_W), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(tx_push), .wdata(tx_data),
      .pop(seq_load), .rdata(txq_head), .full(tx_full), .empty(txq_empty));

   spi_ssel_fifo #(.WIDTH(WORD_W), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(eng_done), .wdata(eng_rx),
      .pop(rx_pop), .rdata(rx_data), .full(rxq_full), .empty(rx_empty));

   spi_ssel_shift #(.WORD_W(WORD_W), .HALF_DIV(HALF_DIV)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(seq_load), .load_word(txq_head),
      .bit_len(len_eff), .miso(miso), .sclk(sclk), .mosi(mosi),
      .done(eng_done), .rx_word(eng_rx));

   spi_ssel_drive #(.NSEL(NSEL)) u_drive (
      .act(act_q), .chan(chan_q), .pol(cfg_pol), .ssel(ssel));

   // register file
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_en  <= 1'b0;
         ctrl_ch  <= '0;
         ctrl_len <= '0;
         cfg_hold <= '0;
         cfg_pol  <= '0;
         st_ovf   <= 1'b0;
         st_done  <= 1'b0;
      end else begin
         if (wr_ctrl) begin
            ctrl_en  <= reg_wdata[CT_EN];
            ctrl_ch  <= reg_wdata[CT_CH_LO +: CHW];
            ctrl_len <= reg_wdata[CT_LEN_LO +: LW];
         end
         if (wr_cfg) begin
            cfg_hold <= reg_wdata[CF_HOLD_LO +: NSEL];
            cfg_pol  <= reg_wdata[CF_POL_LO +: NSEL];
         end
         // hardware set wins over a same-cycle software clear
         st_done <= (st_done & ~(wr_stat & reg_wdata[ST_DONE])) | done_set;
         st_ovf  <= (st_ovf  & ~(wr_stat & reg_wdata[ST_OVF]))  | ovf_set;
      end
   end

   // select sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SQ_IDLE;
         act_q   <= 1'b0;
         chan_q  <= '0;
      end else begin
         unique case (state_q)
            SQ_IDLE: if (go) begin
               state_q <= SQ_LOAD;
               act_q   <= 1'b1;
               chan_q  <= reg_wdata[CT_CH_LO +: CHW];
            end
            SQ_LOAD: state_q <= SQ_RUN;
            SQ_RUN: if (eng_done) begin
               if (txq_empty) begin
                  state_q <= SQ_IDLE;
                  act_q   <= 1'b0;
               end else if (cfg_hold[chan_q]) begin
                  state_q <= SQ_LOAD;
               end else begin
                  state_q <= SQ_GAP;
                  act_q   <= 1'b0;
               end
            end
            SQ_GAP: begin
               state_q <= SQ_LOAD;
               act_q   <= 1'b1;
            end
            default: state_q <= SQ_IDLE;
         endcase
      end
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         RA_CTRL: begin
            reg_rdata[CT_EN]               = ctrl_en;
            reg_rdata[CT_CH_LO +: CHW]     = ctrl_ch;
            reg_rdata[CT_LEN_LO +: LW]     = ctrl_len;
         end
         RA_CFG: begin
            reg_rdata[CF_HOLD_LO +: NSEL]  = cfg_hold;
            reg_rdata[CF_POL_LO +: NSEL]   = cfg_pol;
         end
         RA_STAT: begin
            reg_rdata[ST_TXE]  = txq_empty;
            reg_rdata[ST_RXNF] = !rxq_full;
            reg_rdata[ST_OVF]  = st_ovf;
            reg_rdata[ST_DONE] = st_done;
         end
         default: reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/spi_ssel_master_chk.sv
module spi_ssel_master_chk (
   input logic       clk,
   input logic       rst_n,
   input logic [3:0] ssel,
   input logic [3:0] cfg_pol,
   input logic       act_q,
   input logic [1:0] chan_q,
   input logic       sclk,
   input logic       mosi,
   input logic       st_done,
   input logic       st_ovf,
   input logic       eng_done,
   input logic       rxq_full,
   input logic       rx_pop,
   input logic       txq_empty
);
   assert_idle_level_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !act_q |-> (ssel == ~cfg_pol));

   assert_single_active_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(ssel ~^ cfg_pol) <= 1);

   assert_sclk_selected_R3: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> (ssel[chan_q] == cfg_pol[chan_q]));

   assert_mosi_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(mosi));

   assert_start_has_data_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_q) |-> !$past(txq_empty));

   assert_done_releases_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(st_done) |-> (ssel == ~cfg_pol));

   assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (eng_done && rxq_full && !rx_pop) |=> st_ovf);
endmodule

bind spi_ssel_master spi_ssel_master_chk u_chk (
   .clk(clk), .rst_n(rst_n), .ssel(ssel), .cfg_pol(cfg_pol),
   .act_q(act_q), .chan_q(chan_q), .sclk(sclk), .mosi(mosi),
   .st_done(st_done), .st_ovf(st_ovf), .eng_done(eng_done),
   .rxq_full(rxq_full), .rx_pop(rx_pop), .txq_empty(txq_empty));

// File: tb/sim_spi_ssel_master.sv
`timescale 1ns/1ps
module sim_spi_ssel_master;
   localparam int RXD = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [1:0]  reg_addr = 2'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        tx_push = 1'b0;
   logic [31:0] tx_data = '0;
   logic        tx_full;
   logic        rx_pop = 1'b0;
   logic [31:0] rx_data;
   logic        rx_empty;
   logic        sclk, mosi, miso;
   logic [3:0]  ssel;
   logic        lb = 1'b1;

   assign miso = lb ? mosi : 1'b0;

   spi_ssel_master #(.TX_DEPTH(8), .RX_DEPTH(RXD), .HALF_DIV(2)) u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .tx_push(tx_push),
      .tx_data(tx_data), .tx_full(tx_full), .rx_pop(rx_pop), .rx_data(rx_data),
      .rx_empty(rx_empty), .sclk(sclk), .mosi(mosi), .miso(miso), .ssel(ssel));

   always #5 clk = ~clk;

   int tests = 0, fails = 0, cyc = 0;
   int rises = 0, bad = 0, gaps = 0, ncap = 0;
   logic cap [64];
   logic [1:0] exp_chan = 2'd0;
   logic [3:0] exp_pol = 4'h0;
   logic xfer_on = 1'b0, prev_act = 1'b0, sclk_prev = 1'b0;
   logic [31:0] wq [5];

   // monitor: samples outputs away from the active edge
   always @(negedge clk) begin
      logic [3:0] e;
      logic cur;
      e = ~exp_pol;
      e[exp_chan] = exp_pol[exp_chan];
      cur = (ssel[exp_chan] == exp_pol[exp_chan]);
      if (sclk && !sclk_prev) begin
         rises++;
         if (ncap < 64) cap[ncap] = mosi;
         ncap++;
      end
      if (sclk && ssel != e) bad++;
      if (xfer_on && (((ssel ^ ~exp_pol) & ~(4'b0001 << exp_chan)) != 4'h0)) bad++;
      if (xfer_on && prev_act && !cur) gaps++;
      prev_act  = cur;
      sclk_prev = sclk;
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         fails++;
         $display("FAIL watchdog (all requirements) actual=%0d expected<=100000 cycles", cyc);
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   task automatic chk(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // all tasks start and end just after a falling edge
   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [31:0] d);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic push(input logic [31:0] w);
      tx_push = 1'b1; tx_data = w;
      @(negedge clk);
      tx_push = 1'b0;
   endtask

   task automatic pop(output logic [31:0] w);
      w = rx_data;
      rx_pop = 1'b1;
      @(negedge clk);
      rx_pop = 1'b0;
   endtask

   function automatic int nbits(input int lenf);
      return (lenf >= 31) ? 32 : lenf + 1;
   endfunction

   function automatic logic [31:0] lmask(input int b);
      return (b >= 32) ? 32'hFFFF_FFFF : ((32'h1 << b) - 32'h1);
   endfunction

   task automatic wait_done(output logic [31:0] st);
      for (int i = 0; i < 20000; i++) begin
         rd(2'd2, st);
         if (st[3]) break;
         @(negedge clk);
      end
   endtask

   task automatic t_reset;
      logic [31:0] v;
      chk(ssel == 4'hF, "R1 ssel after reset", {28'd0, ssel}, 32'hF);
      chk(sclk == 1'b0, "R1 sclk after reset", {31'd0, sclk}, 32'd0);
      chk(rx_empty == 1'b1, "R1 rx empty after reset", {31'd0, rx_empty}, 32'd1);
      rd(2'd2, v); chk(v == 32'h3, "R1 R10 status reset value", v, 32'h3);
      rd(2'd0, v); chk(v == 32'h0, "R1 control reset value", v, 32'h0);
      rd(2'd1, v); chk(v == 32'h0, "R1 config reset value", v, 32'h0);
   endtask

   task automatic t_idle_pol;
      wr(2'd1, 32'h0000_5000);
      chk(ssel == 4'hA, "R2 idle levels follow polarity", {28'd0, ssel}, 32'hA);
      wr(2'd1, 32'h0000_0000);
      chk(ssel == 4'hF, "R2 idle levels back to high", {28'd0, ssel}, 32'hF);
   endtask

   task automatic t_no_start;
      logic [31:0] v;
      rises = 0;
      wr(2'd0, 32'h0000_0703);
      repeat (20) @(negedge clk);
      chk(rises == 0, "R6 no sclk on start with empty queue", rises, 0);
      chk(ssel == 4'hF, "R6 select idle on start with empty queue", {28'd0, ssel}, 32'hF);
      rd(2'd2, v); chk(v[3] == 1'b0, "R6 no done flag without data", v, 32'h3);
      rd(2'd0, v); chk(v == 32'h0000_0701, "R6 start bit reads zero", v, 32'h0000_0701);
   endtask

   task automatic run_xfer(input logic [1:0] ch, input logic [3:0] pol, input logic [3:0] hold,
                           input int lenf, input int n);
      logic [31:0] v, r;
      int b;
      b = nbits(lenf);
      exp_chan = ch; exp_pol = pol;
      wr(2'd1, {16'd0, pol, hold, 8'd0});
      for (int i = 0; i < n; i++) push(wq[i]);
      rd(2'd2, v); chk(v[0] == 1'b0, "R10 tx-empty bit clear with data", v, 32'h2);
      rises = 0; bad = 0; gaps = 0; ncap = 0; prev_act = 1'b0;
      xfer_on = 1'b1;
      wr(2'd0, {18'd0, 6'(lenf), 4'd0, ch, 2'b11});
      wait_done(v);
      xfer_on = 1'b0;
      chk(v[3] == 1'b1, "R7 done flag set", v, 32'h8);
      chk(ssel == ~pol, "R7 select released with done", {28'd0, ssel}, {28'd0, ~pol});
      chk(rises == n * b, "R4 sclk pulses per word", rises, n * b);
      chk(bad == 0, "R3 select levels during transfer", bad, 0);
      chk(gaps == (hold[ch] ? 1 : n), "R9 select gaps between words", gaps, hold[ch] ? 1 : n);
      if (n > RXD) begin
         chk(v[2] == 1'b1, "R8 overflow bit set", v, 32'hC);
         chk(v[1] == 1'b0, "R10 rx-not-full bit clear", v, 32'h8);
      end
      for (int i = 0; i < ((n > RXD) ? RXD : n); i++) begin
         pop(r);
         chk(r == (wq[i] & lmask(b)), "R4 received word", r, wq[i] & lmask(b));
      end
      chk(rx_empty == 1'b1, "R8 dropped word not queued", {31'd0, rx_empty}, 32'd1);
      wr(2'd2, 32'h0000_000C);
      rd(2'd2, v); chk(v[3:2] == 2'b00, "R7 R8 write-one clears flags", v, 32'h3);
   endtask

   task automatic t_order;
      int idx, mism, b;
      wq[0] = 32'h1234_5ABC;
      run_xfer(2'd1, 4'h0, 4'h2, 11, 1);
      b = 12; idx = 0; mism = 0;
      for (int by = 0; by * 8 < b; by++) begin
         int nb;
         nb = (b - by * 8 > 8) ? 8 : b - by * 8;
         for (int j = nb - 1; j >= 0; j--) begin
            if (cap[idx] !== wq[0][by * 8 + j]) mism++;
            idx++;
         end
      end
      chk(mism == 0, "R5 serial bit order", mism, 0);
   endtask

   task automatic t_gapped;
      wq[0] = 32'h0000_00A5; wq[1] = 32'h0000_003C; wq[2] = 32'h0000_00F0;
      run_xfer(2'd2, 4'h4, 4'h0, 7, 3);
   endtask

   task automatic t_held;
      wq[0] = 32'h0000_BEEF; wq[1] = 32'h0000_1234; wq[2] = 32'h0000_8001;
      run_xfer(2'd3, 4'h8, 4'h8, 15, 3);
   endtask

   task automatic t_cap;
      wq[0] = 32'hDEAD_BEEF;
      run_xfer(2'd0, 4'h1, 4'h0, 40, 1);
   endtask

   task automatic t_overflow;
      for (int i = 0; i < 5; i++) wq[i] = 32'h11 * (i + 1);
      run_xfer(2'd0, 4'h0, 4'h1, 7, 5);
   endtask

   task automatic t_collide;
      logic [31:0] v, r;
      int guard;
      exp_chan = 2'd1; exp_pol = 4'h0;
      wr(2'd1, 32'h0);
      push(32'h0000_0096);
      wr(2'd0, 32'h0000_0707);
      guard = 0;
      while (ssel[1] == 1'b0 && guard < 2000) begin
         wr(2'd2, 32'h0000_0008);
         guard++;
      end
      rd(2'd2, v);
      chk(v[3] == 1'b1, "R7 set wins over same-cycle clear", v, 32'hB);
      wr(2'd2, 32'h0000_0008);
      rd(2'd2, v);
      chk(v[3] == 1'b0, "R7 lone clear takes effect", v, 32'h3);
      pop(r);
      chk(r == 32'h96, "R4 collide word received", r, 32'h96);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_idle_pol();
      t_no_start();
      t_order();
      t_gapped();
      t_held();
      t_cap();
      t_overflow();
      t_collide();
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule